// File: doc/BRIEF.md
# Two-Descriptor Byte DMA for a Parallel Peripheral

This block moves bytes between system memory and a byte-wide parallel peripheral. Software prepares up to two transfer descriptors, called context A and context B, and arms each one with its own valid bit. The engine works through the armed context one byte at a time. When that context is empty, the engine reports completion and turns to the other context if it is armed. Software can therefore refill one descriptor while the engine drains the other.

Each descriptor is one 64-bit word. It holds a byte base address, a 12-bit byte count and an end-of-stream flag. When a descriptor with that flag set is finished, the device gets a one-cycle terminal-count strobe. A small register window gives access to both descriptors, to a control word and to a read-only diagnostic word. The diagnostic word shows the context in use, whether the engine is busy, and how many bytes remain.

The memory side is a plain request/acknowledge port carrying one byte per beat. The device side has two valid/ready byte handshakes, one for each direction.

Top module: `pp_dma`

## Requirements
- R1: After reset the control word and the diagnostic word both read zero. No memory request, device strobe or interrupt is active.
- R2: The register window decodes address 0 as context A, 1 as context B, 2 as control and 3 as diagnostic. A context word places the base address in bits 31:0, the byte count in bits 43:32 and the end-of-stream flag in bit 63, and it reads back exactly as written.
- R3: With direction 0 (memory to device), the engine reads bytes from consecutive addresses, starting at the base. It presents each byte to the device in address order, one per accepted handshake.
- R4: With direction 1 (device to memory), the engine writes each accepted device byte to consecutive addresses, starting at the base.
- R5: The engine serves the context in use if it is valid, and otherwise switches to the other context if that one is valid. After reset, context A is in use. When a context drains, its valid bit clears and its own completion interrupt pulses for exactly one cycle. The engine then moves on to the other context.
- R6: Finishing a context whose end-of-stream flag is set pulses the terminal-count output in the same cycle as the completion interrupt. A context with the flag clear finishes without that pulse.
- R7: Clearing control bit 1 (enable) freezes the engine. No memory request and no device handshake occur, and the byte counter holds its value. Setting the bit again resumes from the same point.
- R8: Diagnostic bit 0 gives the context in use (0 = A, 1 = B). Bit 1 is set while the engine is enabled and not idle. Bits 13:2 hold the bytes left, and this count falls by one per byte moved.
- R9: In direction 1, a base address that is not a multiple of 64 raises the memory-error interrupt and clears the enable bit, and no byte is transferred.
- R10: If the low 12 bits of the base plus the count exceed 4096, the memory-error interrupt fires, the enable bit clears and no byte is moved. A transfer that ends exactly on the 4 KiB boundary is accepted.
- R11: An error response on the memory port raises the memory-error interrupt and clears the enable bit. The context stays valid and the byte counter keeps the bytes left.
- R12: A context with a count of zero completes at once, with no memory requests and no device handshakes.
- R13: The control word has these bits: bit 0 direction, bit 1 enable, bit 2 channel reset, bit 3 arm B, bit 4 arm A. Writing 1 to bit 3 or bit 4 arms that context; writing 0 there leaves it unchanged, and bit 2 reads as 0. Writing 1 to bit 2 clears both valid bits, the enable, the direction, the context in use and the counter, but keeps the descriptor words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index (0 ctx A, 1 ctx B, 2 control, 3 diagnostic) |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write (1) or a read (0) |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Memory completes the requested beat |
| mem_err | input | 1 | Beat completed with an error (valid with mem_ack) |
| mem_rdata | input | 8 | Read byte (valid with mem_ack) |
| dev_out_valid | output | 1 | Byte offered to the device |
| dev_out_data | output | 8 | Byte to the device |
| dev_out_ready | input | 1 | Device accepts the offered byte |
| dev_in_valid | input | 1 | Device offers a byte |
| dev_in_data | input | 8 | Byte from the device |
| dev_in_ready | output | 1 | Engine accepts the device byte |
| dev_tc | output | 1 | Terminal-count strobe to the device |
| irq_ctx_a | output | 1 | Context A completion pulse |
| irq_ctx_b | output | 1 | Context B completion pulse |
| irq_merr | output | 1 | Memory-error pulse |

## Verification
The bench builds the block with its default parameters: a 4 KiB page, 64-byte alignment for input and a 12-bit count. With the 12-bit count, short descriptors can sit just below, exactly on and just across the page boundary. This makes the accept/reject edge of R10 a direct test. The bench memory model is 8 KiB, so it covers the addresses used, including one past the first page. The model can inject an error response at a chosen address, which exercises a failure part way through a context.

// File: rtl/pp_dma_pkg.sv
// Package: shared constants, descriptor type and engine states for the
// two-descriptor byte DMA. Assumes one byte moves per memory beat.
package pp_dma_pkg;
    localparam int ADDR_W        = 32;
    localparam int LEN_W         = 12;
    localparam int BYTE_W        = 8;
    localparam int CTX_W         = 64;
    localparam int NUM_CTX       = 2;
    localparam int REG_AW        = 2;
    localparam int PAGE_BITS     = 12;
    localparam int IN_ALIGN_BITS = 6;

    // descriptor field positions (decoded by software, so fixed)
    localparam int LEN_LSB  = 32;
    localparam int LAST_BIT = 63;

    // register window
    localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd2;
    localparam logic [REG_AW-1:0] ADDR_DIAG = 2'd3;

    // control word bits
    localparam int CB_DIR = 0;
    localparam int CB_EN  = 1;
    localparam int CB_RST = 2;
    localparam int CB_VB  = 3;
    localparam int CB_VA  = 4;

    // diagnostic word layout
    localparam int DG_SEL = 0;
    localparam int DG_ACT = 1;
    localparam int DG_CNT = 2;

    typedef struct packed {
        logic              last;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] base;
    } ctx_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOAD, ST_RD, ST_PUSH, ST_PULL, ST_WR, ST_DONE
    } xfer_st_t;

    function automatic ctx_t unpack_ctx(input logic [CTX_W-1:0] w);
        ctx_t c;
        c.base = w[ADDR_W-1:0];
        c.len  = w[LEN_LSB +: LEN_W];
        c.last = w[LAST_BIT];
        return c;
    endfunction

    // valid-bit position in the control word for context i (A=0, B=1)
    function automatic int valid_bit(input int i);
        return CB_VA - i;
    endfunction
endpackage

// File: rtl/pp_dma_bounds.sv
// Module: descriptor legality check. Flags a transfer that would run past
// the end of its page, or an input transfer whose base is not aligned.
// Assumes the byte count fits in PAGE_BITS bits.
module pp_dma_bounds
    import pp_dma_pkg::*;
#(
    parameter int PAGE_B  = PAGE_BITS,
    parameter int ALIGN_B = IN_ALIGN_BITS
) (
    input  ctx_t ctx_i,
    input  logic dir_i,
    output logic err_o
);
    localparam int END_W = PAGE_B + 1;
    localparam logic [END_W-1:0] PAGE_SIZE = END_W'(1) << PAGE_B;

    logic [END_W-1:0] end_off;
    logic             crosses;
    logic             misaligned;

    // offset just past the last byte, inside the page
    always_comb begin
        end_off    = {1'b0, ctx_i.base[PAGE_B-1:0]} + END_W'(ctx_i.len);
        crosses    = end_off > PAGE_SIZE;
        misaligned = dir_i && (|ctx_i.base[ALIGN_B-1:0]);
        err_o      = crosses || misaligned;
    end
endmodule

// File: rtl/pp_dma_regs.sv
// Module: register window. Holds both descriptors, their valid bits, the
// enable and direction bits, and returns the read word. The engine clears a
// valid bit on completion and the enable bit on an error.
module pp_dma_regs
    import pp_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [CTX_W-1:0]  reg_wdata,
    input  logic [CTX_W-1:0]  diag_i,
    input  logic              sel_i,
    input  logic              done_i,
    input  logic              stop_i,
    output logic [CTX_W-1:0]  reg_rdata,
    output ctx_t              cur_ctx_o,
    output logic [NUM_CTX-1:0] valid_o,
    output logic              en_o,
    output logic              dir_o,
    output logic              soft_rst_o
);
    logic [CTX_W-1:0] words [NUM_CTX];
    logic             ctrl_wr;
    logic             en_q, dir_q;
    logic [CTX_W-1:0] ctrl_rd;

    assign ctrl_wr    = reg_we && (reg_addr == ADDR_CTRL);
    assign soft_rst_o = ctrl_wr && reg_wdata[CB_RST];

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
        logic [CTX_W-1:0] word_q;
        logic             vld_q;
        logic             wr_ctx;

        assign wr_ctx = reg_we && (reg_addr == REG_AW'(i));

        // descriptor storage, kept across a channel reset
        always_ff @(posedge clk) begin
            if (!rst_n)      word_q <= '0;
            else if (wr_ctx) word_q <= reg_wdata;
        end

        // valid bit: armed by software, dropped on completion or reset
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst_o)                        vld_q <= 1'b0;
            else if (ctrl_wr && reg_wdata[valid_bit(i)])     vld_q <= 1'b1;
            else if (done_i && (sel_i == 1'(i)))             vld_q <= 1'b0;
        end

        assign words[i]   = word_q;
        assign valid_o[i] = vld_q;
    end

    // enable and direction bits
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_o) begin
            en_q  <= 1'b0;
            dir_q <= 1'b0;
        end else if (ctrl_wr) begin
            en_q  <= reg_wdata[CB_EN];
            dir_q <= reg_wdata[CB_DIR];
        end else if (stop_i) begin
            en_q  <= 1'b0;
        end
    end

    // control word as seen by a read
    always_comb begin
        ctrl_rd         = '0;
        ctrl_rd[CB_DIR] = dir_q;
        ctrl_rd[CB_EN]  = en_q;
        ctrl_rd[CB_VA]  = valid_o[0];
        ctrl_rd[CB_VB]  = valid_o[1];
    end

    // read mux
    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = ctrl_rd;
            ADDR_DIAG: reg_rdata = diag_i;
            default:   reg_rdata = words[reg_addr[0]];
        endcase
    end

    assign cur_ctx_o = unpack_ctx(words[sel_i]);
    assign en_o      = en_q;
    assign dir_o     = dir_q;
endmodule

// File: rtl/pp_dma_xfer.sv
// Module: transfer sequencer. Picks the context, loads it, moves bytes one
// at a time between the memory port and the device handshake, and signals
// completion, terminal count and errors. Assumes the memory acknowledges a
// beat only while it is requested.
module pp_dma_xfer
    import pp_dma_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst_i,
    input  logic               en_i,
    input  logic               dir_i,
    input  ctx_t               cur_ctx_i,
    input  logic [NUM_CTX-1:0] valid_i,
    input  logic               bound_err_i,
    input  logic               mem_ack_i,
    input  logic               mem_err_i,
    input  logic [BYTE_W-1:0]  mem_rdata_i,
    input  logic               dev_out_ready_i,
    input  logic               dev_in_valid_i,
    input  logic [BYTE_W-1:0]  dev_in_data_i,
    output logic               sel_o,
    output logic               done_o,
    output logic               tc_o,
    output logic               stop_o,
    output logic               active_o,
    output logic [LEN_W-1:0]   cnt_o,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic [BYTE_W-1:0]  mem_wdata_o,
    output logic               dev_out_valid_o,
    output logic [BYTE_W-1:0]  dev_out_data_o,
    output logic               dev_in_ready_o
);
    xfer_st_t          st_q;
    logic              sel_q;
    logic              last_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] data_q;
    logic              beat_ok;
    logic              beat_bad;
    logic              final_byte;

    assign beat_ok    = en_i && mem_ack_i && !mem_err_i;
    assign beat_bad   = en_i && mem_ack_i && mem_err_i;
    assign final_byte = (cnt_q == LEN_W'(1));

    // sequencer state, pointer, counter and byte holding register
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_i) begin
            st_q   <= ST_IDLE;
            sel_q  <= 1'b0;
            last_q <= 1'b0;
            addr_q <= '0;
            cnt_q  <= '0;
            data_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (en_i) begin
                    if (valid_i[sel_q])       st_q  <= ST_LOAD;
                    else if (valid_i[!sel_q]) sel_q <= !sel_q;
                end
                ST_LOAD: if (en_i) begin
                    last_q <= cur_ctx_i.last;
                    addr_q <= cur_ctx_i.base;
                    cnt_q  <= cur_ctx_i.len;
                    if (bound_err_i)                 st_q <= ST_IDLE;
                    else if (cur_ctx_i.len == '0)    st_q <= ST_DONE;
                    else if (dir_i)                  st_q <= ST_PULL;
                    else                             st_q <= ST_RD;
                end
                ST_RD: begin
                    if (beat_bad) st_q <= ST_IDLE;
                    else if (beat_ok) begin
                        data_q <= mem_rdata_i;
                        st_q   <= ST_PUSH;
                    end
                end
                ST_PUSH: if (en_i && dev_out_ready_i) begin
                    addr_q <= addr_q + 1'b1;
                    cnt_q  <= cnt_q - 1'b1;
                    st_q   <= final_byte ? ST_DONE : ST_RD;
                end
                ST_PULL: if (en_i && dev_in_valid_i) begin
                    data_q <= dev_in_data_i;
                    st_q   <= ST_WR;
                end
                ST_WR: begin
                    if (beat_bad) st_q <= ST_IDLE;
                    else if (beat_ok) begin
                        addr_q <= addr_q + 1'b1;
                        cnt_q  <= cnt_q - 1'b1;
                        st_q   <= final_byte ? ST_DONE : ST_PULL;
                    end
                end
                ST_DONE: begin
                    sel_q <= !sel_q;
                    st_q  <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // handshake and event outputs
    always_comb begin
        mem_req_o       = en_i && ((st_q == ST_RD) || (st_q == ST_WR));
        mem_we_o        = (st_q == ST_WR);
        mem_addr_o      = addr_q;
        mem_wdata_o     = data_q;
        dev_out_valid_o = en_i && (st_q == ST_PUSH);
        dev_out_data_o  = data_q;
        dev_in_ready_o  = en_i && (st_q == ST_PULL);
        done_o          = (st_q == ST_DONE);
        tc_o            = (st_q == ST_DONE) && last_q;
        stop_o          = ((st_q == ST_LOAD) && en_i && bound_err_i)
                        || (((st_q == ST_RD) || (st_q == ST_WR)) && beat_bad);
        active_o        = en_i && (st_q != ST_IDLE);
    end

    assign sel_o = sel_q;
    assign cnt_o = cnt_q;
endmodule

// File: rtl/pp_dma.sv
// Module: top of the two-descriptor byte DMA. Connects the register window,
// the legality check and the sequencer, and builds the diagnostic word.
module pp_dma
    import pp_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [7:0]        mem_rdata,
    output logic              dev_out_valid,
    output logic [7:0]        dev_out_data,
    input  logic              dev_out_ready,
    input  logic              dev_in_valid,
    input  logic [7:0]        dev_in_data,
    output logic              dev_in_ready,
    output logic              dev_tc,
    output logic              irq_ctx_a,
    output logic              irq_ctx_b,
    output logic              irq_merr
);
    ctx_t               cur_ctx;
    logic [NUM_CTX-1:0] ctx_valid;
    logic               ch_en, ch_dir, soft_rst;
    logic               xfer_sel, xfer_done, xfer_stop, xfer_act, bound_err;
    logic [LEN_W-1:0]   xfer_cnt;
    logic [CTX_W-1:0]   diag_word;

    // diagnostic word: context in use, busy, bytes left
    always_comb begin
        diag_word                     = '0;
        diag_word[DG_SEL]             = xfer_sel;
        diag_word[DG_ACT]             = xfer_act;
        diag_word[DG_CNT +: LEN_W]    = xfer_cnt;
    end

    pp_dma_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .diag_i     (diag_word),
        .sel_i      (xfer_sel),
        .done_i     (xfer_done),
        .stop_i     (xfer_stop),
        .reg_rdata  (reg_rdata),
        .cur_ctx_o  (cur_ctx),
        .valid_o    (ctx_valid),
        .en_o       (ch_en),
        .dir_o      (ch_dir),
        .soft_rst_o (soft_rst)
    );

    pp_dma_bounds u_bounds (
        .ctx_i (cur_ctx),
        .dir_i (ch_dir),
        .err_o (bound_err)
    );

    pp_dma_xfer u_xfer (
        .clk             (clk),
        .rst_n           (rst_n),
        .soft_rst_i      (soft_rst),
        .en_i            (ch_en),
        .dir_i           (ch_dir),
        .cur_ctx_i       (cur_ctx),
        .valid_i         (ctx_valid),
        .bound_err_i     (bound_err),
        .mem_ack_i       (mem_ack),
        .mem_err_i       (mem_err),
        .mem_rdata_i     (mem_rdata),
        .dev_out_ready_i (dev_out_ready),
        .dev_in_valid_i  (dev_in_valid),
        .dev_in_data_i   (dev_in_data),
        .sel_o           (xfer_sel),
        .done_o          (xfer_done),
        .tc_o            (dev_tc),
        .stop_o          (xfer_stop),
        .active_o        (xfer_act),
        .cnt_o           (xfer_cnt),
        .mem_req_o       (mem_req),
        .mem_we_o        (mem_we),
        .mem_addr_o      (mem_addr),
        .mem_wdata_o     (mem_wdata),
        .dev_out_valid_o (dev_out_valid),
        .dev_out_data_o  (dev_out_data),
        .dev_in_ready_o  (dev_in_ready)
    );

    assign irq_ctx_a = xfer_done && !xfer_sel;
    assign irq_ctx_b = xfer_done &&  xfer_sel;
    assign irq_merr  = xfer_stop;
endmodule

// File: rtl/pp_dma_check.sv
// Module: protocol checker for pp_dma, attached by bind below.
module pp_dma_check (
    input logic        clk,
    input logic        rst_n,
    input logic        en,
    input logic        irq_a,
    input logic        irq_b,
    input logic        irq_merr,
    input logic        dev_tc,
    input logic        mem_req,
    input logic        dev_out_valid,
    input logic        dev_out_ready,
    input logic        dev_in_ready,
    input logic [11:0] cnt
);
    // completion pulses last exactly one cycle
    assert_irq_a_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_a |=> !irq_a);
    assert_irq_b_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_b |=> !irq_b);
    assert_one_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_a, irq_b}));
    // terminal count only together with a completion
    assert_tc_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dev_tc |-> (irq_a || irq_b));
    // frozen channel makes no request and no handshake
    assert_frozen_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!mem_req && !dev_out_valid && !dev_in_ready));
    // each byte handed to the device lowers the counter by one
    assert_cnt_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_out_valid && dev_out_ready) |=> (cnt == $past(cnt) - 12'd1));
    // only one direction is active at a time
    assert_dir_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_out_valid && dev_in_ready));
    // an error stops the channel
    assert_merr_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_merr |=> !en);
endmodule

bind pp_dma pp_dma_check u_check (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (ch_en),
    .irq_a         (irq_ctx_a),
    .irq_b         (irq_ctx_b),
    .irq_merr      (irq_merr),
    .dev_tc        (dev_tc),
    .mem_req       (mem_req),
    .dev_out_valid (dev_out_valid),
    .dev_out_ready (dev_out_ready),
    .dev_in_ready  (dev_in_ready),
    .cnt           (xfer_cnt)
);

// File: tb/pp_dma_test.sv
// Bench: scoreboard of expected device bytes and memory writes, filled by
// driver tasks and drained by a monitor at the falling edge.
module pp_dma_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        mem_req, mem_we, mem_ack, mem_err;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        dev_out_valid, dev_in_ready, dev_tc;
    logic [7:0]  dev_out_data;
    logic        dev_out_ready = 1'b1;
    logic        dev_in_valid = 1'b1;
    logic [7:0]  dev_seq = 8'h40;
    logic        irq_ctx_a, irq_ctx_b, irq_merr;

    logic [7:0]  mem [0:8191];
    logic        err_en = 1'b0;
    logic [31:0] err_addr = '0;

    int n_chk = 0, n_fail = 0;
    int n_irq_a = 0, n_irq_b = 0, n_merr = 0, n_tc = 0, n_out = 0, n_mreq = 0;
    logic [7:0]  exp_out[$];
    logic [39:0] exp_wr[$];
    logic [7:0]  exp_seq = 8'h40;

    always #2.5 clk = ~clk;

    pp_dma uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .dev_out_valid(dev_out_valid),
        .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
        .dev_in_valid(dev_in_valid), .dev_in_data(dev_seq),
        .dev_in_ready(dev_in_ready), .dev_tc(dev_tc),
        .irq_ctx_a(irq_ctx_a), .irq_ctx_b(irq_ctx_b), .irq_merr(irq_merr)
    );

    // memory and device models
    assign mem_ack   = mem_req;
    assign mem_err   = mem_req && err_en && (mem_addr == err_addr);
    assign mem_rdata = mem[mem_addr[12:0]];

    always @(posedge clk) begin
        if (mem_req && mem_we && !mem_err) mem[mem_addr[12:0]] <= mem_wdata;
        if (dev_in_valid && dev_in_ready) dev_seq <= dev_seq + 8'd1;
    end

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard and counts events
    always @(negedge clk) if (rst_n) begin
        if (dev_out_valid && dev_out_ready) begin
            n_out++;
            if (exp_out.size() == 0) check(1'b0, "R3 unexpected byte", {56'd0, dev_out_data}, 64'd0);
            else begin
                logic [7:0] e;
                e = exp_out.pop_front();
                check(dev_out_data == e, "R3 byte order", {56'd0, dev_out_data}, {56'd0, e});
            end
        end
        if (mem_req && mem_we && !mem_err) begin
            if (exp_wr.size() == 0) check(1'b0, "R4 unexpected write", {24'd0, mem_addr, mem_wdata}, 64'd0);
            else begin
                logic [39:0] w;
                w = exp_wr.pop_front();
                check({mem_addr, mem_wdata} == w, "R4 write addr/data",
                      {24'd0, mem_addr, mem_wdata}, {24'd0, w});
            end
        end
        if (mem_req)   n_mreq++;
        if (irq_ctx_a) n_irq_a++;
        if (irq_ctx_b) n_irq_b++;
        if (irq_merr)  n_merr++;
        if (dev_tc)    n_tc++;
    end

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [63:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [63:0] mk_ctx(input bit last, input int len, input logic [31:0] base);
        return {last, 19'd0, 12'(len), base};
    endfunction

    task automatic push_out(input int base, input int len);
        for (int i = 0; i < len; i++) exp_out.push_back(mem[13'(base + i)]);
    endtask

    task automatic push_in(input int base, input int len);
        for (int i = 0; i < len; i++) begin
            exp_wr.push_back({32'(base + i), exp_seq});
            exp_seq = exp_seq + 8'd1;
        end
    endtask

    task automatic wait_idle(input string req);
        logic [63:0] c, g;
        bit ok = 1'b0;
        for (int i = 0; i < 400 && !ok; i++) begin
            rd(2'd2, c);
            rd(2'd3, g);
            if (c[4:3] == 2'b00 && !g[1]) ok = 1'b1;
        end
        check(ok, req, c, 64'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        check(1'b0, "watchdog", 64'd0, 64'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] d;
        int snap;
        for (int i = 0; i < 8192; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd2, d); check(d == 64'd0, "R1 ctrl after reset", d, 64'd0);
        rd(2'd3, d); check(d == 64'd0, "R1 diag after reset", d, 64'd0);
        check(!mem_req && !dev_out_valid && !irq_ctx_a && !irq_merr, "R1 outputs idle",
              {60'd0, mem_req, dev_out_valid, irq_ctx_a, irq_merr}, 64'd0);

        // R2 R3 R5 R6: A then B, memory to device
        wr(2'd0, mk_ctx(1, 5, 32'h100));
        wr(2'd1, mk_ctx(0, 3, 32'h205));
        rd(2'd0, d); check(d == 64'h8000_0005_0000_0100, "R2 ctx A readback", d, 64'h8000_0005_0000_0100);
        push_out(32'h100, 5); push_out(32'h205, 3);
        wr(2'd2, 64'h1A);
        wait_idle("R5 both contexts drain");
        check(exp_out.size() == 0, "R3 all bytes seen", 64'(exp_out.size()), 64'd0);
        check(n_irq_a == 1 && n_irq_b == 1, "R5 one completion each", 64'(n_irq_a * 16 + n_irq_b), 64'h11);
        check(n_tc == 1, "R6 tc only for last-flag context", 64'(n_tc), 64'd1);
        rd(2'd2, d); check(d == 64'h2, "R5 valids cleared", d, 64'h2);
        rd(2'd3, d); check(d == 64'h0, "R8 diag back on A, idle", d, 64'h0);

        // R7 R8 freeze
        dev_out_ready = 1'b0;
        wr(2'd0, mk_ctx(0, 4, 32'h300));
        push_out(32'h300, 4);
        wr(2'd2, 64'h12);
        repeat (6) @(negedge clk);
        rd(2'd3, d); check(d == 64'h12, "R8 diag busy on A with 4 left", d, 64'h12);
        wr(2'd2, 64'h10);
        dev_out_ready = 1'b1;
        snap = n_out;
        repeat (6) @(negedge clk);
        check(n_out == snap, "R7 no handshake while frozen", 64'(n_out), 64'(snap));
        rd(2'd3, d); check(d == 64'h10, "R7 counter held while frozen", d, 64'h10);
        wr(2'd2, 64'h02);
        wait_idle("R7 resumes");
        check(exp_out.size() == 0 && n_irq_a == 2, "R7 finished after resume", 64'(n_irq_a), 64'd2);

        // R4 device to memory, A armed while B in use
        wr(2'd0, mk_ctx(1, 4, 32'h400));
        push_in(32'h400, 4);
        wr(2'd2, 64'h13);
        wait_idle("R4 input drains");
        check(exp_wr.size() == 0, "R4 all writes seen", 64'(exp_wr.size()), 64'd0);
        check(n_tc == 2 && n_irq_a == 3, "R6 tc on input context", 64'(n_tc), 64'd2);
        rd(2'd3, d); check(d == 64'h1, "R8 in-use now B", d, 64'h1);

        // R9 misaligned input base
        snap = n_mreq;
        wr(2'd0, mk_ctx(0, 4, 32'h410));
        wr(2'd2, 64'h13);
        repeat (10) @(negedge clk);
        check(n_merr == 1, "R9 merr on misaligned input", 64'(n_merr), 64'd1);
        check(n_mreq == snap, "R9 no memory beat", 64'(n_mreq), 64'(snap));
        rd(2'd2, d); check(d == 64'h11, "R9 enable cleared, A still valid", d, 64'h11);

        // R13 channel reset
        wr(2'd2, 64'h04);
        rd(2'd2, d); check(d == 64'h0, "R13 ctrl cleared", d, 64'h0);
        rd(2'd3, d); check(d == 64'h0, "R13 diag cleared", d, 64'h0);
        rd(2'd0, d); check(d == mk_ctx(0, 4, 32'h410), "R13 descriptor kept", d, mk_ctx(0, 4, 32'h410));
        wr(2'd2, 64'h00);
        rd(2'd2, d); check(d == 64'h0, "R13 writing 0 does not arm", d, 64'h0);

        // R10 page boundary: exact fit accepted, one over rejected
        wr(2'd0, mk_ctx(0, 3, 32'hFFD));
        push_out(32'hFFD, 3);
        wr(2'd2, 64'h12);
        wait_idle("R10 exact fit drains");
        check(n_merr == 1 && exp_out.size() == 0, "R10 exact fit accepted", 64'(n_merr), 64'd1);
        snap = n_mreq;
        wr(2'd1, mk_ctx(0, 3, 32'h1FFE));
        wr(2'd2, 64'h0A);
        repeat (10) @(negedge clk);
        check(n_merr == 2 && n_mreq == snap, "R10 crossing rejected", 64'(n_merr), 64'd2);
        rd(2'd2, d); check(d == 64'h08, "R10 enable cleared", d, 64'h08);
        wr(2'd2, 64'h04);

        // R12 zero-length contexts
        snap = n_mreq;
        wr(2'd0, mk_ctx(0, 0, 32'h500));
        wr(2'd1, mk_ctx(1, 0, 32'h600));
        wr(2'd2, 64'h1A);
        wait_idle("R12 zero-length drains");
        check(n_irq_a == 5 && n_irq_b == 2, "R12 both complete", 64'(n_irq_a * 16 + n_irq_b), 64'h52);
        check(n_mreq == snap, "R12 no memory beats", 64'(n_mreq), 64'(snap));
        check(n_tc == 3, "R6 tc on zero-length last", 64'(n_tc), 64'd3);

        // R11 memory error part way
        err_en = 1'b1; err_addr = 32'h702;
        wr(2'd0, mk_ctx(0, 4, 32'h700));
        push_out(32'h700, 2);
        wr(2'd2, 64'h12);
        repeat (20) @(negedge clk);
        check(n_merr == 3 && n_irq_a == 5, "R11 merr, no completion", 64'(n_merr), 64'd3);
        rd(2'd2, d); check(d == 64'h10, "R11 enable cleared, A valid", d, 64'h10);
        rd(2'd3, d); check(d == 64'h08, "R11 two bytes left", d, 64'h08);
        check(exp_out.size() == 0, "R11 bytes before error", 64'(exp_out.size()), 64'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule